// File: doc/BRIEF.md
# Signed Word Requantizer

This block turns a signed two's-complement word of one width into a signed word of another width, with no clock. The relation between the two width parameters fixes the behaviour when the block is elaborated. A narrower output is rounded to nearest, with ties going upward, and clamped at the positive limit. A wider output keeps the input value and scales it up by appending zero fraction bits. Equal widths give a plain copy.

One or two channels share a single parameter set, and each channel is converted without reference to the other. Channels are packed side by side on flat buses, with channel 0 in the least significant slice. The block is meant to sit between arithmetic stages that grow or shrink word length, for example after an adder tree or ahead of a wider accumulator. The data path is purely combinational, so no valid/ready pair is carried and there is no back-pressure: whatever stage drives the block owns the handshake.

Top module: `requantizer`

## Requirements
- R1: When IN_W > OUT_W, with D = IN_W − OUT_W, each output equals floor(x / 2^D + 1/2) for the signed input x. An exact half rounds toward plus infinity (for D = 4, input 8 gives 1 and input −8 gives 0).
- R2: When the rounded result of a positive input exceeds 2^(OUT_W−1) − 1, the output is that maximum positive code (for 12 to 8 bits, inputs 2040 through 2047 give 127).
- R3: A negative input never saturates. The most negative input gives −2^(OUT_W−1), and any negative input gives an output of zero or below.
- R4: When IN_W < OUT_W, the output is the input shifted left by OUT_W − IN_W places. The input bits sit in the top of the output word and the low bits are zero.
- R5: When IN_W = OUT_W, the output is bit-for-bit equal to the input.
- R6: With NUM_CH = 2, channel k uses bits [k·IN_W +: IN_W] of the input and bits [k·OUT_W +: OUT_W] of the output. Each channel's result depends only on its own input slice.
- R7: The output follows the input with no register stage. A new input is reflected at the output within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | NUM_CH*IN_W | Packed signed input words, channel 0 in the low slice |
| word_out | output | NUM_CH*OUT_W | Packed signed requantized words, channel 0 in the low slice |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the input and the output. The bench changes the inputs 1 ns after a rising edge and compares the outputs at the following falling edge. A behavioural integer model, evaluated in that same cycle, supplies the expected value. Three instances cover the rounding, extension and copy variants, and both channels receive different values on every cycle, so that any leak from one channel into the other shows up.

// File: rtl/requant_pkg.sv
package requant_pkg;

  typedef enum logic [1:0] {
    RQ_ROUND  = 2'd0,
    RQ_EXTEND = 2'd1,
    RQ_PASS   = 2'd2
  } rq_mode_e;

  function automatic rq_mode_e rq_pick(input int in_w, input int out_w);
    if (in_w > out_w)      return RQ_ROUND;
    else if (in_w < out_w) return RQ_EXTEND;
    else                   return RQ_PASS;
  endfunction

endpackage

// File: rtl/rq_round.sv
module rq_round #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  word_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int KEEP = OUT_W + 1;
  localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [KEEP-1:0] kept;
  logic [KEEP-1:0] halved;
  logic            ovf;

  // upper OUT_W bits plus the first dropped bit (the rounding bit)
  assign kept   = word_i[IN_W-1 -: KEEP];
  // signed increment at the rounding bit, then drop it
  assign halved = {kept[KEEP-1], kept[KEEP-1:1]} + {{(KEEP-1){1'b0}}, kept[0]};
  assign ovf    = halved[KEEP-1] != halved[KEEP-2];
  assign word_o = ovf ? MAXPOS : halved[OUT_W-1:0];

  always_comb begin
    if (!$isunknown(word_i)) begin
      assert_neg_no_sat_R3: assert (!(ovf && word_i[IN_W-1]))
        else $error("negative input drove the incrementer into overflow");
    end
  end
endmodule

// File: rtl/rq_extend.sv
module rq_extend #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 10
) (
  input  logic [IN_W-1:0]  word_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int PAD = OUT_W - IN_W;
  assign word_o = {word_i, {PAD{1'b0}}};
endmodule

// File: rtl/rq_pass.sv
module rq_pass #(
  parameter int W = 8
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  assign word_o = word_i;
endmodule

// File: rtl/requantizer.sv
module requantizer #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH*IN_W-1:0]  word_in,
  output logic [NUM_CH*OUT_W-1:0] word_out
);
  import requant_pkg::*;
  localparam rq_mode_e MODE = rq_pick(IN_W, OUT_W);

  initial begin
    assert_ch_count_R6: assert (NUM_CH == 1 || NUM_CH == 2)
      else $error("channel count must be 1 or 2");
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [IN_W-1:0]  x;
    logic [OUT_W-1:0] y;
    assign x = word_in[ch*IN_W +: IN_W];
    assign word_out[ch*OUT_W +: OUT_W] = y;

    if (MODE == RQ_ROUND) begin : g_round
      localparam int DROP = IN_W - OUT_W;
      localparam logic signed [IN_W+1:0] HALF = (IN_W+2)'(1) << (DROP - 1);
      localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};
      logic signed [IN_W+1:0] err;

      rq_round #(.IN_W(IN_W), .OUT_W(OUT_W)) u_round (.word_i(x), .word_o(y));

      // residual between the input and the scaled-back output
      assign err = $signed({{2{x[IN_W-1]}}, x}) -
                   $signed({{2{y[OUT_W-1]}}, y, {DROP{1'b0}}});

      always_comb begin
        if (!$isunknown(x)) begin
          assert_round_err_R1: assert (err >= -HALF && (err < HALF || y == MAXPOS))
            else $error("rounding residual out of range");
          assert_sign_kept_R2: assert (x[IN_W-1] || !y[OUT_W-1])
            else $error("non-negative input gave negative output");
          assert_neg_nonpos_R3: assert (!x[IN_W-1] || y[OUT_W-1] || y == '0)
            else $error("negative input gave positive output");
        end
      end
    end else if (MODE == RQ_EXTEND) begin : g_ext
      localparam int PAD = OUT_W - IN_W;
      rq_extend #(.IN_W(IN_W), .OUT_W(OUT_W)) u_ext (.word_i(x), .word_o(y));

      always_comb begin
        if (!$isunknown(x)) begin
          assert_ext_value_R4: assert (($signed(y) >>> PAD) == $signed({{PAD{x[IN_W-1]}}, x}))
            else $error("extended word does not scale back to input");
        end
      end
    end else begin : g_pass
      rq_pass #(.W(IN_W)) u_pass (.word_i(x), .word_o(y));

      always_comb begin
        if (!$isunknown(x)) begin
          assert_pass_equal_R5: assert (y == x)
            else $error("pass-through word differs");
        end
      end
    end
  end
endmodule

// File: tb/requantizer_tb.sv
module requantizer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [23:0] rnd_in;  logic [15:0] rnd_out;
  logic [5:0]  ext_in;  logic [9:0]  ext_out;
  logic [15:0] pas_in;  logic [15:0] pas_out;

  requantizer #(.IN_W(12), .OUT_W(8), .NUM_CH(2))  u_dut  (.word_in(rnd_in), .word_out(rnd_out));
  requantizer #(.IN_W(6),  .OUT_W(10), .NUM_CH(1)) u_ext  (.word_in(ext_in), .word_out(ext_out));
  requantizer #(.IN_W(8),  .OUT_W(8), .NUM_CH(2))  u_pass (.word_in(pas_in), .word_out(pas_out));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic int ref_round(input int x);
    int r;
    r = (x + 8) >>> 4;          // D = 4, half = 8
    if (r > 127) r = 127;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string round_tag(input int x, input bit second);
    if (second)     return "R6";
    if (x >= 2040)  return "R2";
    if (x < 0)      return "R3";
    return "R1";
  endfunction

  task automatic apply(input int a0, input int a1, input int e0, input int p0, input int p1);
    @(posedge clk); #1;
    rnd_in = {12'(a1), 12'(a0)};
    ext_in = 6'(e0);
    pas_in = {8'(p1), 8'(p0)};
    @(negedge clk); // same-cycle result (R7)
    chk(round_tag(a0, 0), int'($signed(rnd_out[7:0])),  ref_round(a0));
    chk(round_tag(a1, 1), int'($signed(rnd_out[15:8])), ref_round(a1));
    chk("R4", int'($signed(ext_out)), e0 * 16);
    chk("R5", int'($signed(pas_out[7:0])), p0);
    chk("R6", int'($signed(pas_out[15:8])), p1);
  endtask

  initial begin
    rnd_in = '0; ext_in = '0; pas_in = '0;
    @(negedge clk);
    // R7: zero input settles to zero with no register in the path
    chk("R7", int'($signed(rnd_out[7:0])), 0);
    chk("R7", int'($signed(ext_out)), 0);
    // R1 ties and near-ties
    apply(8, -8, 31, -128, 127);
    apply(7, -9, -32, 127, -128);
    apply(24, -24, 1, 0, -1);
    // R2 saturation boundary
    apply(2047, 2039, -1, 85, -86);
    apply(2040, 2032, 17, -1, 1);
    // R3 negative extremes
    apply(-2048, -2041, -17, 64, -64);
    apply(-1, -2047, 0, 3, 100);
    // R6 independence: change one channel only
    apply(100, 2047, 5, 10, 20);
    apply(100, -2048, 5, 10, -20);
    for (int i = 0; i < 400; i++) begin
      int a0, a1, e0, p0, p1;
      a0 = int'($urandom_range(0, 4095)) - 2048;
      a1 = int'($urandom_range(0, 4095)) - 2048;
      e0 = int'($urandom_range(0, 63)) - 32;
      p0 = int'($urandom_range(0, 255)) - 128;
      p1 = int'($urandom_range(0, 255)) - 128;
      apply(a0, a1, e0, p0, p1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule